// File: doc/BRIEF.md
# UART FIFO Control and Status Register Pair

This block is a pair of byte-wide registers that sit between a host bus and the transmit and receive FIFOs of a UART. The control byte carries one flush command per direction and two interrupt enables. A flush command is a self-clearing pulse that empties only the FIFO, so the character in the shift register is not disturbed. The status byte reports whether each FIFO is empty. It also holds two sticky error flags: transmit overflow, raised by a push into a full transmit FIFO, and receive underflow, raised by a pop from an empty receive FIFO.

The host picks a register with one select line. Read data is a combinational mux of the selected byte. Writes take effect on the clock edge that samples the write strobe. The FIFOs report their fill counts and their push or pop attempts. They receive one-cycle flush pulses in return. A single registered interrupt line goes to the host whenever an enabled error flag is set.

Top module: `uart_fifo_csr`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0xC0 while both counts are zero, `irq` is 0, and both flush outputs are 0.
- R2: A control write (`bus_sel`=0) with bit 7 set drives `tx_flush` high for exactly the one cycle after the write edge. Bit 6 does the same for `rx_flush`. A write with the bit clear gives no pulse, and the two directions are independent.
- R3: In the control byte, bits 1 (transmit-overflow enable) and 0 (receive-underflow enable) are stored and read back. Bits 7 to 2 always read 0, including the flush bits that were just written as 1.
- R4: Status bit 7 reads 1 when `tx_count` is zero, and bit 6 reads 1 when `rx_count` is zero. Each reflects the count sampled at the previous clock edge.
- R5: After a flush command, the matching empty bit reads 1 from the write edge, and it stays 1 through the cycle in which the flush pulse is high, whatever the count input shows.
- R6: A `tx_push` while `tx_count` equals DEPTH sets status bit 1 at that edge. A push while the FIFO is not full leaves the bit unchanged.
- R7: An `rx_pop` while `rx_count` is zero sets status bit 0 at that edge. A pop from a non-empty FIFO leaves the bit unchanged.
- R8: Status bits 1 and 0 stay set until a status write (`bus_sel`=1) has a 1 in that bit position. Writing 0 has no effect. A new error event in the same cycle as a clear leaves the flag set.
- R9: Status bits 5 to 2 always read 0. A status write changes neither the empty bits nor the control byte.
- R10: `irq` is registered and, one cycle later, equals (status bit 1 AND control bit 1) OR (status bit 0 AND control bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_push | input | 1 | Push attempt into the transmit FIFO |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_pop | input | 1 | Pop attempt from the receive FIFO |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |
| rx_flush | output | 1 | One-cycle receive FIFO flush pulse |
| irq | output | 1 | Interrupt request to the host |

## Verification
The properties take for granted that neither fill count ever goes above DEPTH. They also assume that the push, pop, write and select inputs are stable around the rising edge, so an error event and a status write in the same cycle are both seen at one edge. The bench changes every input on the falling edge and keeps both counts between 0 and DEPTH. Because the bench holds the counts steady across a flush rather than modelling the FIFO, the forced-empty window and the return to the count-derived value can both be seen.

// File: rtl/uart_fifo_csr_pkg.sv
package uart_fifo_csr_pkg;
    localparam int NDIR       = 2;
    localparam int DIR_RX     = 0;
    localparam int DIR_TX     = 1;
    // Bit positions are base + direction index (rx = 0, tx = 1)
    localparam int FLUSH_BASE = 6;
    localparam int EMPTY_BASE = 6;
    localparam int EN_BASE    = 0;
    localparam int FLAG_BASE  = 0;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    typedef struct packed {
        logic [NDIR-1:0] irq_en;
        logic [NDIR-1:0] flush;
        logic            irq;
    } csr_state_t;
endpackage

// File: rtl/uart_fcsr_flag.sv
module uart_fcsr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // a new event outranks a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/uart_fcsr_empty.sv
module uart_fcsr_empty #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flush_now_i,
    input  logic             flush_hold_i,
    output logic             empty_o
);
    logic empty_d, empty_q;

    always_comb begin
        empty_d = (count_i == '0);
        if (flush_now_i || flush_hold_i) empty_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) empty_q <= 1'b1;
        else        empty_q <= empty_d;
    end

    assign empty_o = empty_q;
endmodule

// File: rtl/uart_fifo_csr.sv
module uart_fifo_csr
    import uart_fifo_csr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_push,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pop,
    output logic             tx_flush,
    output logic             rx_flush,
    output logic             irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    csr_state_t      st_d, st_q;
    logic            wr_ctrl, wr_stat;
    logic [CNT_W-1:0] cnt_a [NDIR];
    logic [NDIR-1:0] evt, flag, empty;
    logic [7:0]      ctrl_byte, status_byte;
    logic            unused_rsvd;

    assign wr_ctrl = bus_we && (bus_sel == SEL_CTRL);
    assign wr_stat = bus_we && (bus_sel == SEL_STAT);
    assign unused_rsvd = ^bus_wdata[5:2];

    assign cnt_a[DIR_RX] = rx_count;
    assign cnt_a[DIR_TX] = tx_count;
    assign evt[DIR_RX]   = rx_pop  && (rx_count == '0);
    assign evt[DIR_TX]   = tx_push && (tx_count == FULL_CNT);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NDIR; i++) begin
            st_d.flush[i] = wr_ctrl && bus_wdata[FLUSH_BASE + i];
            if (wr_ctrl) st_d.irq_en[i] = bus_wdata[EN_BASE + i];
        end
        st_d.irq = |(flag & st_q.irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        uart_fcsr_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt[g]),
            .clr_i  (wr_stat && bus_wdata[FLAG_BASE + g]),
            .flag_o (flag[g])
        );
        uart_fcsr_empty #(.CNT_W(CNT_W)) u_empty (
            .clk          (clk),
            .rst_n        (rst_n),
            .count_i      (cnt_a[g]),
            .flush_now_i  (st_d.flush[g]),
            .flush_hold_i (st_q.flush[g]),
            .empty_o      (empty[g])
        );
    end

    always_comb begin
        ctrl_byte = '0;
        status_byte = '0;
        for (int i = 0; i < NDIR; i++) begin
            ctrl_byte[EN_BASE + i]      = st_q.irq_en[i];
            status_byte[EMPTY_BASE + i] = empty[i];
            status_byte[FLAG_BASE + i]  = flag[i];
        end
    end

    assign bus_rdata = (bus_sel == SEL_STAT) ? status_byte : ctrl_byte;
    assign tx_flush  = st_q.flush[DIR_TX];
    assign rx_flush  = st_q.flush[DIR_RX];
    assign irq       = st_q.irq;
endmodule

// File: rtl/uart_fifo_csr_chk.sv
module uart_fifo_csr_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [7:0]       bus_wdata,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_push,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_pop,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             irq,
    input logic [7:0]       ctrl_byte,
    input logic [7:0]       status_byte
);
    // R2
    tx_flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel && bus_wdata[7]) |=> tx_flush);
    // R2
    rx_flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !(bus_we && !bus_sel && bus_wdata[6])) |=> !rx_flush);
    // R3
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_byte[7:2] == 6'd0);
    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> status_byte[7]);
    // R6
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_count == CNT_W'(DEPTH)) |=> status_byte[1]);
    // R7
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_count == '0) |=> status_byte[0]);
    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[1] && !(bus_we && bus_sel && bus_wdata[1])) |=> status_byte[1]);
    // R9
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5:2] == 4'd0);
    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past((status_byte[1] & ctrl_byte[1]) | (status_byte[0] & ctrl_byte[0])));
endmodule

bind uart_fifo_csr uart_fifo_csr_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .tx_count(tx_count), .tx_push(tx_push),
    .rx_count(rx_count), .rx_pop(rx_pop), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .irq(irq), .ctrl_byte(ctrl_byte),
    .status_byte(status_byte)
);

// File: tb/tb_uart_fifo_csr.sv
module tb_uart_fifo_csr;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [CNT_W-1:0] tx_count = '0, rx_count = '0;
    logic tx_push = 1'b0, rx_pop = 1'b0;
    logic tx_flush, rx_flush, irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_fifo_csr #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_count(tx_count),
        .tx_push(tx_push), .rx_count(rx_count), .rx_pop(rx_pop),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] data);
        bus_sel = sel;
        #0.5;
        data = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 status", v, 8'hC0);
        chk("R1 irq/flush", {5'd0, irq, tx_flush, rx_flush}, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        tx_count = 5'd3; rx_count = 5'd2; step(2);
        rd(1'b1, v); chk("R4 both nonempty", v, 8'h00);
        wr(1'b0, 8'h80);
        chk("R2 tx pulse only", {6'd0, tx_flush, rx_flush}, 8'h02);
        rd(1'b1, v); chk("R5 tx empty forced", v, 8'h80);
        step(1);
        chk("R2 tx pulse ends", {7'd0, tx_flush}, 8'h00);
        rd(1'b1, v); chk("R5 tx empty held", v, 8'h80);
        step(1);
        rd(1'b1, v); chk("R4 back to count", v, 8'h00);
        wr(1'b0, 8'h40);
        chk("R2 rx pulse only", {6'd0, tx_flush, rx_flush}, 8'h01);
        rd(1'b1, v); chk("R5 rx empty forced", v, 8'h40);
        tx_count = '0; rx_count = '0; step(2);
        rd(1'b1, v); chk("R4 both empty", v, 8'hC0);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(1'b0, 8'hFF);
        chk("R2 both pulses", {6'd0, tx_flush, rx_flush}, 8'h03);
        rd(1'b0, v); chk("R3 readback", v, 8'h03);
        wr(1'b0, 8'h01);
        rd(1'b0, v); chk("R3 rx enable only", v, 8'h01);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R3 cleared", v, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        tx_count = 5'(DEPTH - 1);
        @(negedge clk); tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        rd(1'b1, v); chk("R6 push not full", v & 8'h03, 8'h00);
        tx_count = 5'(DEPTH);
        @(negedge clk); tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        rd(1'b1, v); chk("R6 overflow set", v & 8'h03, 8'h02);
        step(1);
        chk("R10 disabled irq", {7'd0, irq}, 8'h00);
        wr(1'b0, 8'h02);
        chk("R10 irq not yet", {7'd0, irq}, 8'h00);
        step(1);
        chk("R10 irq raised", {7'd0, irq}, 8'h01);
        wr(1'b1, 8'h02);
        rd(1'b1, v); chk("R8 overflow cleared", v & 8'h03, 8'h00);
        chk("R10 irq lags clear", {7'd0, irq}, 8'h01);
        step(1);
        chk("R10 irq dropped", {7'd0, irq}, 8'h00);
        wr(1'b0, 8'h00);
        tx_count = '0; step(1);
    endtask

    task automatic t_underflow();
        logic [7:0] v;
        rx_count = 5'd1;
        @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        rd(1'b1, v); chk("R7 pop nonempty", v & 8'h03, 8'h00);
        rx_count = '0;
        @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        rd(1'b1, v); chk("R7 underflow set", v & 8'h03, 8'h01);
        wr(1'b0, 8'h01); step(1);
        chk("R10 rx irq", {7'd0, irq}, 8'h01);
        wr(1'b0, 8'h02); step(1);
        chk("R10 other enable", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R8 write 0 keeps", v & 8'h03, 8'h01);
        wr(1'b1, 8'hFC);
        rd(1'b1, v); chk("R9 status reads", v, 8'hC1);
        rd(1'b0, v); chk("R9 ctrl untouched", v, 8'h02);
        @(negedge clk);
        rx_pop = 1'b1; bus_we = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h01;
        @(negedge clk);
        rx_pop = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(1'b1, v); chk("R8 set beats clear", v & 8'h03, 8'h01);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R8 write 1 clears", v & 8'h03, 8'h00);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_flush();
        t_ctrl();
        t_overflow();
        t_underflow();
        t_sticky();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule